// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a synchronous host reach an external asynchronous static RAM. The RAM has a 16-bit address and 16-bit data, and each byte of the data word has its own active-low select. The host presents one request at a time through a valid/ready handshake. Each request carries an address, a write flag, write data and an active-high byte-enable mask. A read returns its data with a one-cycle valid pulse. The memory side produces active-low chip select, write enable, output enable and one select per byte lane, all from flops. The bidirectional data bus is split into an outgoing word, a drive enable and an incoming word.

The access timing is set with nanosecond-scale parameters given in picoseconds, together with the clock period. Each wait is the minimum time divided by the clock period and rounded up, and it is never less than one cycle. Reads hold the strobes for the read wait and sample the bus on the last edge of that wait. Writes keep output enable high for the whole access. A write first waits with the bus released, so that the memory has time to stop driving. It then pulses write enable while driving data, and it keeps driving data for one cycle after write enable rises. Every access ends with a cycle in which all strobes are inactive. A request whose mask is all zero completes without selecting the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, write enable, output enable and every byte select are high, the data drive enable is low, ready is high and read-valid is low.
- R2: A read holds chip select and output enable low and write enable high for RD_CYC cycles. RD_CYC is the largest of the read-cycle, address-access, output-enable and byte-select times divided by the clock period, rounded up, with a minimum of 1. Read-valid rises RD_CYC clock edges after the accepting edge.
- R3: Read data is sampled on the last edge of the read wait. Lanes whose enable bit is 1 return the bus byte. Lanes whose enable bit is 0 return zero. Mask bit 0 covers data bits 7:0 and mask bit 1 covers bits 15:8.
- R4: While chip select is low, byte select i equals the inverse of mask bit i. While chip select is high, all byte selects are high.
- R5: A write keeps output enable high throughout. It holds chip select low with the bus released for REL_CYC cycles, where REL_CYC is the bus-release time in cycles. It then holds write enable low for exactly WP_CYC cycles, where WP_CYC is the larger of the write-pulse and data-setup times in cycles. It keeps chip select low and the address stable for one more cycle after write enable rises.
- R6: A write stores only the lanes whose enable bit is 1. Other lanes of that word keep their previous contents.
- R7: A request with an all-zero mask never lowers chip select. For a read, it returns read-valid on the edge after acceptance, with data zero.
- R8: When chip select rises, all strobes are high and the bus is released for at least that cycle, before the next access can start.
- R9: Ready is low from the accepting edge until the access has finished. Read-valid is high for exactly one cycle.
- R10: The data drive enable is high only in the cycles where write enable is low and in the one cycle that follows. It is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Active-high byte-enable mask, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_bsel_n | output | DATA_W/8 | Active-low byte selects, bit 0 = lower byte |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
Two things are hard to observe from the ports. The first is whether unselected lanes are really masked: a real memory leaves those lanes floating, so a faulty design could still see zeros there. The bench memory model therefore drives a fixed non-zero pattern on every deselected lane during reads, and any leak shows up in the returned data. The second is timing: byte-masked writes need to be proven both by strobe timing and by their effect on the array. A bus monitor counts chip-select cycles, write-pulse length and drive-enable cycles for each request. The vector table then writes partial words and reads them back lane by lane. It also includes zero-mask requests placed between normal accesses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_GAP
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

   // Minimum time in ps converted to clock cycles, rounded up, floor of one.
   function automatic int unsigned wait_cycles(input int unsigned t_ps, input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC  = 3,
   parameter int unsigned REL_CYC = 2,
   parameter int unsigned WP_CYC  = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   input  logic    req_any,
   output logic    accept,
   output logic    ready,
   output logic    capture,
   output logic    sel_nxt,
   output logic    rd_valid,
   output strobe_t strb
);

   localparam int unsigned MAX_CYC = max2(max2(RD_CYC, REL_CYC), WP_CYC);
   localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   seq_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              null_rd;
   strobe_t           strb_d;

   assign accept = ready & req_valid;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      capture = 1'b0;
      null_rd = 1'b0;
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (!req_any) begin
                  state_d = ST_GAP;
                  null_rd = ~req_write;
               end else if (req_write) begin
                  state_d = ST_WSETUP;
                  cnt_d   = CNT_W'(REL_CYC - 1);
               end else begin
                  state_d = ST_READ;
                  cnt_d   = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (cnt_q == '0) begin
               state_d = ST_GAP;
               capture = 1'b1;
            end
         end
         ST_WSETUP: begin
            if (cnt_q == '0) begin
               state_d = ST_WPULSE;
               cnt_d   = CNT_W'(WP_CYC - 1);
            end
         end
         ST_WPULSE: begin
            if (cnt_q == '0) state_d = ST_WHOLD;
         end
         ST_WHOLD: state_d = ST_GAP;
         ST_GAP:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   // Strobes decoded from the next state, then registered.
   always_comb begin
      strb_d = STROBE_IDLE;
      unique case (state_d)
         ST_READ: begin
            strb_d.cs_n = 1'b0;
            strb_d.oe_n = 1'b0;
         end
         ST_WSETUP: strb_d.cs_n = 1'b0;
         ST_WPULSE: begin
            strb_d.cs_n  = 1'b0;
            strb_d.we_n  = 1'b0;
            strb_d.drive = 1'b1;
         end
         ST_WHOLD: begin
            strb_d.cs_n  = 1'b0;
            strb_d.drive = 1'b1;
         end
         default: strb_d = STROBE_IDLE;
      endcase
   end

   assign sel_nxt = ~strb_d.cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         strb     <= STROBE_IDLE;
         ready    <= 1'b1;
         rd_valid <= 1'b0;
      end else begin
         state_q  <= state_d;
         cnt_q    <= cnt_d;
         strb     <= strb_d;
         ready    <= (state_d == ST_IDLE);
         rd_valid <= capture | null_rd;
      end
   end

   AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R9
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready); // R9
   AST_NULL_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_any) |=> strb.cs_n); // R7
   AST_WE_RISE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb.we_n) |-> !strb.cs_n); // R5
   AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.oe_n |-> (strb.we_n && !strb.cs_n)); // R2

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              be_in,
   input  logic [LANE_W-1:0] wdata_in,
   input  logic              sel_nxt,
   input  logic              capture,
   input  logic [LANE_W-1:0] dq_in,
   output logic              bsel_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rdata
);

   logic be_q;
   logic be_now;

   assign be_now = accept ? be_in : be_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_q   <= 1'b0;
         bsel_n <= 1'b1;
         dq_out <= '0;
         rdata  <= '0;
      end else begin
         bsel_n <= ~(sel_nxt & be_now);
         if (accept) begin
            be_q   <= be_in;
            dq_out <= wdata_in;
            rdata  <= '0;
         end else if (capture) begin
            rdata <= be_q ? dq_in : '0;
         end
      end
   end

   AST_LANE_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !be_q) |=> (rdata == '0)); // R3
   AST_LANE_CAPTURE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && be_q) |=> (rdata == $past(dq_in))); // R3

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned CLK_PS       = 4000,
   parameter int unsigned T_RCYC_PS    = 10000,
   parameter int unsigned T_AACC_PS    = 10000,
   parameter int unsigned T_OEVAL_PS   = 5000,
   parameter int unsigned T_BSVAL_PS   = 5000,
   parameter int unsigned T_WPULSE_PS  = 9000,
   parameter int unsigned T_DSETUP_PS  = 6000,
   parameter int unsigned T_RELEASE_PS = 6000,
   localparam int unsigned LANES       = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_bsel_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned RD_CYC  = wait_cycles(max2(max2(T_RCYC_PS, T_AACC_PS),
                                                      max2(T_OEVAL_PS, T_BSVAL_PS)), CLK_PS);
   localparam int unsigned WP_CYC  = wait_cycles(max2(T_WPULSE_PS, T_DSETUP_PS), CLK_PS);
   localparam int unsigned REL_CYC = wait_cycles(T_RELEASE_PS, CLK_PS);

   if (CLK_PS == 0) begin : g_bad_clk
      $error("CLK_PS must be non-zero");
   end
   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W == 0) begin : g_bad_addr
      $error("ADDR_W must be non-zero");
   end

   logic    accept, capture, sel_nxt;
   strobe_t strb;

   sram_seq #(
      .RD_CYC  (RD_CYC),
      .REL_CYC (REL_CYC),
      .WP_CYC  (WP_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_any   (|req_be),
      .accept    (accept),
      .ready     (req_ready),
      .capture   (capture),
      .sel_nxt   (sel_nxt),
      .rd_valid  (rd_valid),
      .strb      (strb)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane #(.LANE_W(8)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .accept   (accept),
         .be_in    (req_be[g]),
         .wdata_in (req_wdata[g*8 +: 8]),
         .sel_nxt  (sel_nxt),
         .capture  (capture),
         .dq_in    (mem_dq_in[g*8 +: 8]),
         .bsel_n   (mem_bsel_n[g]),
         .dq_out   (mem_dq_out[g*8 +: 8]),
         .rdata    (rd_data[g*8 +: 8])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_addr <= '0;
      else if (accept) mem_addr <= req_addr;
   end

   assign mem_cs_n  = strb.cs_n;
   assign mem_we_n  = strb.we_n;
   assign mem_oe_n  = strb.oe_n;
   assign mem_dq_oe = strb.drive;

   AST_BSEL_ONLY_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bsel_n != '1) |-> !mem_cs_n); // R4
   AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R10
   AST_GAP_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> (mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_bsel_n))); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5
   AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R5

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int unsigned CLK_PS = 4000;

   function automatic int unsigned cyc(input int unsigned t, input int unsigned p);
      int unsigned c;
      c = (t + p - 1) / p;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int unsigned RD  = cyc(10000, CLK_PS);
   localparam int unsigned WP  = cyc(9000, CLK_PS);
   localparam int unsigned REL = cyc(6000, CLK_PS);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [15:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_bsel_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in;

   always #2 clk = ~clk;

   sram_lane_ctrl #(.CLK_PS(CLK_PS)) i_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Memory model: 256 words; deselected lanes show a junk pattern during reads.
   logic [15:0] mem [256];

   always_comb begin
      mem_dq_in = '0;
      if (!mem_cs_n && mem_we_n && !mem_oe_n) begin
         for (int l = 0; l < 2; l++)
            mem_dq_in[l*8 +: 8] = mem_bsel_n[l] ? 8'hA5 : mem[mem_addr[7:0]][l*8 +: 8];
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
         for (int l = 0; l < 2; l++)
            if (!mem_bsel_n[l]) mem[mem_addr[7:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
      end
   end

   // Bus monitor: running totals plus global checks.
   int unsigned cs_total = 0, drv_total = 0, we_run = 0, we_len_last = 0;
   logic [1:0]  bsel_last = 2'b11;
   logic        prev_cs_low = 1'b0;
   int unsigned mon_checks = 0, mon_errs = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_cs_n) begin
            cs_total  <= cs_total + 1;
            bsel_last <= mem_bsel_n;
         end
         if (mem_dq_oe) drv_total <= drv_total + 1;
         if (!mem_we_n) we_run <= we_run + 1;
         else if (we_run != 0) begin
            we_len_last <= we_run;
            we_run      <= 0;
         end
         if (mem_dq_oe || !mem_we_n) begin
            mon_checks <= mon_checks + 1;
            if (!mem_oe_n) begin
               mon_errs <= mon_errs + 1;
               $display("FAIL R10: drive/write with oe_n low, act oe_n=%0b exp 1", mem_oe_n);
            end
         end
         if (prev_cs_low && mem_cs_n) begin
            mon_checks <= mon_checks + 1;
            if (!(mem_we_n && mem_oe_n && !mem_dq_oe && mem_bsel_n == 2'b11)) begin
               mon_errs <= mon_errs + 1;
               $display("FAIL R8: gap cycle act we=%0b oe=%0b drv=%0b bsel=%b exp 1 1 0 11",
                        mem_we_n, mem_oe_n, mem_dq_oe, mem_bsel_n);
            end
         end
         prev_cs_low <= ~mem_cs_n;
      end
   end

   int unsigned checks = 0, errs = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   // {write, addr, be, wdata, expected read data}
   localparam logic [50:0] VEC [0:9] = '{
      {1'b1, 16'h0010, 2'b11, 16'hA1B2, 16'h0000},
      {1'b1, 16'h0020, 2'b11, 16'hC3D4, 16'h0000},
      {1'b1, 16'h0010, 2'b01, 16'hFFEE, 16'h0000},
      {1'b1, 16'h0020, 2'b10, 16'h5566, 16'h0000},
      {1'b1, 16'h0030, 2'b00, 16'h1234, 16'h0000},
      {1'b0, 16'h0010, 2'b11, 16'h0000, 16'hA1EE},
      {1'b0, 16'h0020, 2'b01, 16'h0000, 16'h00D4},
      {1'b0, 16'h0020, 2'b10, 16'h0000, 16'h5500},
      {1'b0, 16'h0030, 2'b11, 16'h0000, 16'h0000},
      {1'b0, 16'h0010, 2'b00, 16'h0000, 16'h0000}
   };

   task automatic xfer(input logic wr, input logic [15:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input logic [15:0] exp);
      int unsigned cs0, drv0, cnt;
      @(negedge clk);
      cs0  = cs_total;
      drv0 = drv_total;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R9", "ready after accept", {31'd0, req_ready}, 32'd0);
      cnt = 0;
      if (!wr) begin
         while (!rd_valid) begin @(negedge clk); cnt++; end
         chk(cnt == ((be == 0) ? 0 : RD), (be == 0) ? "R7" : "R2", "read latency", cnt,
             (be == 0) ? 0 : RD);
         chk(rd_data == exp, (be == 0) ? "R7" : "R3", "read data", {16'd0, rd_data}, {16'd0, exp});
         @(negedge clk);
         chk(!rd_valid, "R9", "valid pulse width", {31'd0, rd_valid}, 32'd0);
         while (!req_ready) @(negedge clk);
      end else begin
         while (!req_ready) begin @(negedge clk); cnt++; end
         chk(cnt == ((be == 0) ? 1 : REL + WP + 2), "R9", "write busy cycles", cnt,
             (be == 0) ? 1 : REL + WP + 2);
         chk(drv_total - drv0 == ((be == 0) ? 0 : WP + 1), "R10", "drive cycles",
             drv_total - drv0, (be == 0) ? 0 : WP + 1);
         if (be != 0)
            chk(we_len_last == WP, "R5", "write pulse length", we_len_last, WP);
      end
      chk(cs_total - cs0 == ((be == 0) ? 0 : (wr ? REL + WP + 1 : RD)),
          (be == 0) ? "R7" : (wr ? "R5" : "R2"), "chip-select cycles", cs_total - cs0,
          (be == 0) ? 0 : (wr ? REL + WP + 1 : RD));
      if (be != 0)
         chk(bsel_last == ~be, "R4", "byte selects", {30'd0, bsel_last}, {30'd0, ~be});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && mem_bsel_n == 2'b11 && !mem_dq_oe,
          "R1", "strobes in reset", {26'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_bsel_n, mem_dq_oe},
          32'h3E);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rd_valid, "R1", "ready/valid after reset", {30'd0, req_ready, rd_valid},
          32'h2);
      chk(mem_cs_n && mem_dq_oe == 1'b0, "R1", "idle bus after reset",
          {30'd0, mem_cs_n, mem_dq_oe}, 32'h2);
      for (int i = 0; i < 10; i++)
         xfer(VEC[i][50], VEC[i][49:34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
      // R6 corner: upper-byte write after full write keeps lower byte
      xfer(1'b1, 16'h0040, 2'b11, 16'h1122, 16'h0);
      xfer(1'b1, 16'h0040, 2'b10, 16'h99FF, 16'h0);
      xfer(1'b0, 16'h0040, 2'b11, 16'h0, 16'h9922); // R6
      // R7 corner: null write between accesses leaves memory untouched
      xfer(1'b1, 16'h0040, 2'b00, 16'h0000, 16'h0);
      xfer(1'b0, 16'h0040, 2'b11, 16'h0, 16'h9922); // R7
      // R3 corner: single lower lane read of a word with both bytes set
      xfer(1'b0, 16'h0040, 2'b01, 16'h0, 16'h0022);
      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errs + mon_errs);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      $display("FAIL watchdog: run did not complete, act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1,
               errs + mon_errs + 1);
      $finish;
   end

endmodule